// File: doc/BRIEF.md
# Grouped Change-of-State Input Interrupt Controller

This block samples a wide bank of digital input lines and presents them through a small byte-wide register window. The lines are divided into groups of eight consecutive lines. Software arms any subset of groups. An armed group records a change of state when any of its lines toggles, and the direction of the toggle does not matter. While any group holds a recorded change, a level interrupt output is asserted.

One register at the top of the window handles interrupts. A write to it loads the per-group arming mask. A read returns the per-group change flags and an active-low pending flag, and that read also acknowledges: the flags clear and the interrupt output drops. Every input passes through a multi-stage synchroniser before it is read or compared. An edge that arrives in the same cycle as the acknowledging read is kept, so no change is lost. Software does any masking of single lines by itself.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Offsets 0, 1 and 2 return the synchronised levels of lines 0-7, 8-15 and 16-23. Offsets 4, 5 and 6 return lines 24-31, 32-39 and 40-47. The lowest line of each byte sits in bit 0. A level applied to a pin becomes readable two clock edges later.
- R2: A read of offset 3 returns 0x00.
- R3: A write to offset 7 loads bits 0-5 of the write data as the arming mask. Bit g arms group g, which covers lines 8g to 8g+7.
- R4: A rising or falling level on any line of an armed group sets that group's change flag, in read bit g of offset 7. The flag is set at the third clock edge after the pin changes.
- R5: A level change on a line of a group that is not armed sets no flag and raises no interrupt.
- R6: `irq_o` is high exactly while at least one change flag is set. Bit 6 of an offset 7 read is the inverse of `irq_o`, so 0 means an interrupt is pending.
- R7: A read of offset 7 clears all change flags at that clock edge. `irq_o` is low in the following cycle unless a new armed edge arrived at the same edge.
- R8: An armed edge that is detected in the same cycle as the acknowledging read is not lost. That read returns the older flags, and the next read reports the new flag.
- R9: After reset the arming mask is 0, all flags are 0, `irq_o` is low and an offset 7 read returns 0x40.
- R10: Bit 7 of an offset 7 read is always 0. Writes to offsets 0 to 6 change neither the arming mask nor the flags.
- R11: Writing 0 to offset 7 disarms every group, and from then on no input change raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Byte offset within the register window |
| bus_rd_i | input | 1 | Read strobe; a read of offset 7 acknowledges at the clock edge |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed offset (combinational) |
| pins_i | input | 48 | Asynchronous input lines |
| irq_o | output | 1 | Level interrupt, high while any change flag is set |

## Verification
The acknowledging read of the interrupt register and the latching of a fresh armed edge can land on the same clock edge. In that case the clear and the set contend for the same flag bits. The bench provokes this by first leaving one group's flag pending. It then toggles a line of another armed group and starts the acknowledging read exactly two edges later, which is the cycle in which the edge detector fires. The read must return only the older group's flag. A second read must then return only the new group's flag, with the pending bit still active.

// File: rtl/cos_pkg.sv
package cos_pkg;
   // byte offset of the interrupt control/status register
   localparam int unsigned IRQ_OFS     = 7;
   // offset left empty between the two input banks
   localparam int unsigned GAP_OFS     = 3;
   // position of the active-low pending flag in the status byte
   localparam int unsigned PEND_BIT    = 6;
   localparam int unsigned BUS_W       = 8;

   typedef enum logic [1:0] {
      ACC_EMPTY = 2'd0,
      ACC_PORT  = 2'd1,
      ACC_CTRL  = 2'd2
   } acc_kind_t;

   // byte offset -> input group, -1 when the offset holds no inputs
   function automatic int ofs_to_group(input int unsigned ofs);
      if (ofs < GAP_OFS)                        return int'(ofs);
      else if (ofs > GAP_OFS && ofs < IRQ_OFS)  return int'(ofs) - 1;
      else                                      return -1;
   endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cos_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cos_group_det.sv
module cos_group_det #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_i,
   input  logic         en_i,
   input  logic         clr_i,
   output logic         hit_o,
   output logic         flag_o
);
   logic [W-1:0] prev_q;
   logic         flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= line_i;
   end

   assign hit_o = |(line_i ^ prev_q);

   // a fresh armed edge wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (hit_o && en_i)    flag_q <= 1'b1;
      else if (clr_i)            flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && en_i) |=> flag_o);

   p_disarmed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !flag_o) |=> !flag_o);

   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(hit_o && en_i)) |=> !flag_o);

   p_collide_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && hit_o && en_i) |=> flag_o);
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
   parameter int GROUPS      = 6,
   parameter int GROUP_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr_i,
   input  logic                        bus_rd_i,
   input  logic                        bus_wr_i,
   input  logic [7:0]                  bus_wdata_i,
   output logic [7:0]                  bus_rdata_o,
   input  logic [GROUPS*GROUP_W-1:0]   pins_i,
   output logic                        irq_o
);
   import cos_pkg::*;

   localparam int LINES = GROUPS * GROUP_W;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(IRQ_OFS);

   if (GROUP_W != BUS_W) begin : g_bad_width
      $error("cos_irq_ctrl: GROUP_W must equal the bus width");
   end
   if (GROUPS != 6) begin : g_bad_groups
      $error("cos_irq_ctrl: the window map holds exactly six groups");
   end
   if ((1 << ADDR_W) != IRQ_OFS + 1) begin : g_bad_addr
      $error("cos_irq_ctrl: ADDR_W must span an eight byte window");
   end

   logic [LINES-1:0]  lines_s;
   logic [GROUPS-1:0] en_q;
   logic [GROUPS-1:0] hit;
   logic [GROUPS-1:0] flag;
   logic              ctrl_sel;
   logic              ack;
   acc_kind_t         kind;

   cos_sync #(.W(LINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_i),
      .q_o   (lines_s)
   );

   assign ctrl_sel = (bus_addr_i == CTRL_ADDR);
   assign ack      = bus_rd_i && ctrl_sel;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      cos_group_det #(.W(GROUP_W)) i_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (lines_s[g*GROUP_W +: GROUP_W]),
         .en_i   (en_q[g]),
         .clr_i  (ack),
         .hit_o  (hit[g]),
         .flag_o (flag[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   en_q <= '0;
      else if (bus_wr_i && ctrl_sel) en_q <= bus_wdata_i[GROUPS-1:0];
   end

   assign irq_o = |flag;

   always_comb begin
      if (ctrl_sel)                                   kind = ACC_CTRL;
      else if (ofs_to_group(int'(bus_addr_i)) >= 0)   kind = ACC_PORT;
      else                                            kind = ACC_EMPTY;
   end

   always_comb begin
      int grp;
      grp         = ofs_to_group(int'(bus_addr_i));
      bus_rdata_o = '0;
      case (kind)
         ACC_CTRL: begin
            bus_rdata_o[GROUPS-1:0] = flag;
            bus_rdata_o[PEND_BIT]   = ~irq_o;
         end
         ACC_PORT: bus_rdata_o = lines_s[grp*GROUP_W +: GROUP_W];
         default:  bus_rdata_o = '0;
      endcase
   end

   p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && ctrl_sel) |=> (en_q == $past(bus_wdata_i[GROUPS-1:0])));

   p_port_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && !ctrl_sel) |=> $stable(en_q));

   p_status_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (bus_rdata_o[7] == 1'b0 && bus_rdata_o[PEND_BIT] == !irq_o));

   p_irq_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(|(hit & en_q))) |=> !irq_o);

   p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == ADDR_W'(GAP_OFS)) |-> (bus_rdata_o == 8'h00));
endmodule

// File: tb/test_cos_irq_ctrl.sv
module test_cos_irq_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  addr;
   logic        rd, wr;
   logic [7:0]  wdata;
   logic [7:0]  rdata;
   logic [47:0] pins;
   logic        irq;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cos_irq_ctrl i_cos_irq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (addr),
      .bus_rd_i    (rd),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .pins_i      (pins),
      .irq_o       (irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at a later negedge
   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R9 irq after reset", {7'd0, irq}, 8'h00);
      bus_read(3'd7, d);
      check("R9 status after reset", d, 8'h40);
   endtask

   task automatic t_inputs();
      logic [7:0] d;
      logic [7:0] exp_b [6];
      pins = 48'hC3_5A_0F_81_7E_A5;
      for (int g = 0; g < 6; g++) exp_b[g] = pins[g*8 +: 8];
      @(negedge clk);
      addr = 3'd0; #1;
      check("R1 not yet visible after one edge", rdata, 8'h00);
      @(negedge clk); #1;
      check("R1 visible after two edges", rdata, exp_b[0]);
      for (int o = 0; o < 3; o++) begin
         bus_read(3'(o), d);
         check("R1 low bank", d, exp_b[o]);
      end
      for (int o = 4; o < 7; o++) begin
         bus_read(3'(o), d);
         check("R1 high bank", d, exp_b[o-1]);
      end
      bus_read(3'd3, d);
      check("R2 gap offset", d, 8'h00);
      bus_read(3'd7, d);
      check("R5 disarmed inputs leave status idle", d, 8'h40);
   endtask

   task automatic t_edges();
      logic [7:0] d;
      bus_write(3'd7, 8'b0000_0101);
      pins[17] = ~pins[17];            // group 2
      @(negedge clk); @(negedge clk);
      check("R4 flag not set before third edge", {7'd0, irq}, 8'h00);
      @(negedge clk);
      check("R6 irq raised", {7'd0, irq}, 8'h01);
      bus_read(3'd7, d);
      check("R4 group 2 flagged, R6 pending low", d, 8'h04);
      check("R7 irq cleared by read", {7'd0, irq}, 8'h00);
      bus_read(3'd7, d);
      check("R7 status after ack", d, 8'h40);
      pins[0] = 1'b0; pins[1] = 1'b1;  // group 0, both directions (bits were 1,0)
      settle();
      bus_read(3'd7, d);
      check("R4 group 0 edge either direction", d, 8'h01);
      pins[12] = ~pins[12];            // group 1, not armed
      settle();
      check("R5 disarmed group no irq", {7'd0, irq}, 8'h00);
      bus_read(3'd7, d);
      check("R5 disarmed group no flag", d, 8'h40);
   endtask

   task automatic t_disarm();
      logic [7:0] d;
      bus_write(3'd7, 8'h00);
      for (int o = 0; o < 7; o++) bus_write(3'(o), 8'hFF);
      pins = ~pins;
      settle();
      check("R11 disarmed all, R10 port writes ignored: irq", {7'd0, irq}, 8'h00);
      bus_read(3'd7, d);
      check("R10 status bit7 zero and no flags", d, 8'h40);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      bus_write(3'd7, 8'hBF);          // bits 7:6 beyond the mask
      pins[9] = ~pins[9];              // group 1
      settle();
      pins[35] = ~pins[35];            // group 4
      @(negedge clk); @(negedge clk);
      bus_read(3'd7, d);               // ack on the edge that latches group 4
      check("R8 ack read returns older flag", d, 8'h02);
      check("R8 irq held by new edge", {7'd0, irq}, 8'h01);
      bus_read(3'd7, d);
      check("R8 new flag survives ack", d, 8'h10);
      bus_read(3'd7, d);
      check("R3 mask still full, status clean", d, 8'h40);
      pins[47] = ~pins[47];            // group 5 armed via bit 5
      settle();
      bus_read(3'd7, d);
      check("R3 bit 5 of mask arms group 5", d, 8'h20);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0; pins = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_inputs();
      t_edges();
      t_disarm();
      t_collide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule